// File: doc/BRIEF.md
# Host-to-16-bit Bus Access Sequencer

This block sits between a host-side request path and a narrow 16-bit peripheral bus. One host access carries one or two 32-bit longwords, a byte address and a byte-enable mask. The sequencer turns that access into one to four 16-bit strobe/acknowledge cycles, each with its own halfword address, write data and two byte-lane selects. On a read it collects the returned halfwords into one completion word.

In the normal mode the halfword address steps up from one cycle to the next, and halfwords whose byte enables are all clear are skipped. In the repeat mode the address stays on one chosen halfword, and every halfword slot of the access is served from that one location. This suits peripherals that present a data register at a single address.

An acknowledge watchdog guards every bus cycle. If it expires, the rest of the access is abandoned, a read completes with all ones, and a sticky flag is set. The flag can drive an optional bus-error interrupt. A misaligned access is rejected without touching the bus.

Top module: `hbus_seq`

## Requirements
- R1: After reset, busy, pb_strobe, cpl_done, cpl_timeout, cpl_misalign, wd_flag and berr_irq are all 0.
- R2: With cfg_inc_off=0, halfword slot i (0..1 for req_dw=0, 0..3 for req_dw=1) produces one bus cycle, in ascending slot order. Each cycle has pb_addr = req_addr[ADDR_W-1:1] + i, pb_lane = req_be[2i+1:2i] (lane bit 0 is the low byte), pb_write = req_write and, on writes, pb_wdata = req_wdata[16i+15:16i].
- R3: With cfg_inc_off=0, a slot whose two byte-enable bits are both 0 gets no bus cycle and reads back as 0. req_be[7:4] is ignored when req_dw=0. If no slot is enabled, cpl_done rises in the cycle after acceptance and no strobe is issued.
- R4: With cfg_inc_off=1, every slot gets a cycle (2 or 4) with pb_lane=2'b11 at address req_addr[ADDR_W-1:1] + s. Here s = cfg_sel for req_dw=1 and s = cfg_sel[0] for req_dw=0. The k-th cycle's data goes to cpl_rdata[16k+15:16k].
- R5: A read completion carries the halfword of slot i in cpl_rdata[16i+15:16i], low slot first, and unused upper bits are 0. A write completes with cpl_rdata = 0.
- R6: pb_strobe, pb_addr, pb_lane, pb_wdata and pb_write hold steady until pb_ack is sampled high. The next cycle, if any, is presented in the very next clock.
- R7: A request with req_dw=0 and req_addr[1:0]!=0, or with req_dw=1 and req_addr[2:0]!=0, completes in the cycle after acceptance with cpl_misalign=1, cpl_rdata=0 and no strobe.
- R8: With cfg_wd_limit=L (latched at acceptance) nonzero, a bus cycle that has held its strobe for L clocks without an acknowledge is aborted. In the next cycle cpl_done and cpl_timeout are 1, the remaining cycles are never issued, and a read returns all ones. An acknowledge in the L-th strobe clock is still accepted. L=0 never times out.
- R9: wd_flag is set by a timeout and stays set until wd_clear is high for a clock; a timeout wins over a clear in the same clock. berr_irq equals wd_flag AND cfg_irq_en.
- R10: A request is accepted at a clock edge where req_valid=1 and busy=0. Requests presented while busy is high are ignored. busy is high from the cycle after acceptance until the cycle in which cpl_done pulses for one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host access present |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 64 | Write data, slot i in bits 16i+15:16i |
| req_be | input | 8 | Byte enables |
| req_dw | input | 1 | 0: one longword, 1: two longwords |
| req_write | input | 1 | 1: write, 0: read |
| cfg_inc_off | input | 1 | Selects repeat mode (address increment disabled) |
| cfg_sel | input | 2 | Halfword chosen in repeat mode |
| cfg_wd_limit | input | 8 | Acknowledge watchdog limit in clocks, 0 disables |
| cfg_irq_en | input | 1 | Enables the bus-error interrupt |
| wd_clear | input | 1 | Clears the sticky watchdog flag |
| busy | output | 1 | Access in progress on the bus |
| cpl_done | output | 1 | One-clock completion pulse |
| cpl_rdata | output | 64 | Assembled read data |
| cpl_timeout | output | 1 | Completion ended by watchdog |
| cpl_misalign | output | 1 | Completion rejected for alignment |
| wd_flag | output | 1 | Sticky watchdog status |
| berr_irq | output | 1 | Bus-error interrupt |
| pb_strobe | output | 1 | Peripheral cycle strobe |
| pb_write | output | 1 | Peripheral cycle direction |
| pb_addr | output | ADDR_W-1 | Halfword address |
| pb_lane | output | 2 | Byte-lane selects |
| pb_wdata | output | 16 | Peripheral write data |
| pb_rdata | input | 16 | Peripheral read data |
| pb_ack | input | 1 | Peripheral acknowledge |

## Verification
The hardest cases to reach are a watchdog expiry partway through a multi-cycle access, and an acknowledge that lands in exactly the last clock the watchdog allows. The bench's peripheral model takes an acknowledge delay and a cycle index from which it stops answering. With these it first acknowledges early cycles and then stalls a later one, and it can also place an acknowledge at delay L-1. The cycle-by-cycle model then predicts which cycles never appear and when the all-ones completion arrives.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
    localparam int HW_BITS = 16;
    localparam int NUM_HW  = 4;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/hbs_pick.sv
// Lowest-set-bit finder over a pending-slot mask.
module hbs_pick #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     mask,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/hbs_plan.sv
// Decides which halfword slots need a bus cycle and checks alignment.
module hbs_plan #(
    parameter int NUM_HW = 4
) (
    input  logic [2:0]          addr_lo,
    input  logic [2*NUM_HW-1:0] be,
    input  logic                dw,
    input  logic                rep,
    output logic [NUM_HW-1:0]   mask,
    output logic                misalign
);
    localparam int HALF = NUM_HW / 2;

    for (genvar i = 0; i < NUM_HW; i++) begin : g_slot
        logic in_range;
        if (i < HALF) begin : g_low
            assign in_range = 1'b1;
        end else begin : g_high
            assign in_range = dw;
        end
        assign mask[i] = in_range & (rep | (|be[2*i +: 2]));
    end

    assign misalign = dw ? (|addr_lo) : (|addr_lo[1:0]);

    always_comb begin
        if (rep) assert (misalign || $countones(mask) == (dw ? NUM_HW : HALF))
            else $error("p_rep_all_slots_r4");
    end
endmodule

// File: rtl/hbs_wdog.sv
// Acknowledge watchdog: counts strobe clocks of the current bus cycle.
module hbs_wdog #(
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             ack,
    input  logic [LIM_W-1:0] limit,
    output logic             expire
);
    logic [LIM_W-1:0] cnt_d, cnt_q;
    logic             armed;
    logic             at_end;

    assign armed  = active && !ack && (limit != '0);
    assign at_end = (cnt_q == limit - LIM_W'(1));
    assign expire = armed && at_end;

    always_comb begin
        cnt_d = '0;
        if (armed && !at_end) cnt_d = cnt_q + LIM_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        active && (limit != '0) |-> cnt_q < limit);
endmodule

// File: rtl/hbus_seq.sv
module hbus_seq
    import hbs_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LIM_W  = 8,
    localparam int PA_W   = ADDR_W - 1,
    localparam int DATA_W = HW_BITS * NUM_HW,
    localparam int BE_W   = 2 * NUM_HW,
    localparam int IDX_W  = $clog2(NUM_HW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    input  logic              req_dw,
    input  logic              req_write,
    input  logic              cfg_inc_off,
    input  logic [IDX_W-1:0]  cfg_sel,
    input  logic [LIM_W-1:0]  cfg_wd_limit,
    input  logic              cfg_irq_en,
    input  logic              wd_clear,
    output logic              busy,
    output logic              cpl_done,
    output logic [DATA_W-1:0] cpl_rdata,
    output logic              cpl_timeout,
    output logic              cpl_misalign,
    output logic              wd_flag,
    output logic              berr_irq,
    output logic              pb_strobe,
    output logic              pb_write,
    output logic [PA_W-1:0]   pb_addr,
    output logic [1:0]        pb_lane,
    output logic [HW_BITS-1:0] pb_wdata,
    input  logic [HW_BITS-1:0] pb_rdata,
    input  logic              pb_ack
);
    typedef struct packed {
        seq_state_e        st;
        logic [NUM_HW-1:0] pend;
        logic [IDX_W-1:0]  idx;
        logic [PA_W-1:0]   base;
        logic [IDX_W-1:0]  roff;
        logic              rep;
        logic              wr;
        logic [LIM_W-1:0]  lim;
        logic [DATA_W-1:0] wdat;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] rdat;
        logic              done;
        logic              tmo;
        logic              mis;
        logic              wflag;
    } seq_regs_t;

    seq_regs_t d, q;

    logic [NUM_HW-1:0] plan_mask;
    logic              plan_mis;
    logic [IDX_W-1:0]  first_idx, next_idx;
    logic              first_any, next_any;
    logic [NUM_HW-1:0] rest_mask;
    logic              wd_expire;
    logic [IDX_W-1:0]  sel_eff;
    logic [IDX_W-1:0]  slot_off;

    hbs_plan #(.NUM_HW(NUM_HW)) u_plan (
        .addr_lo  (req_addr[2:0]),
        .be       (req_be),
        .dw       (req_dw),
        .rep      (cfg_inc_off),
        .mask     (plan_mask),
        .misalign (plan_mis)
    );

    hbs_pick #(.N(NUM_HW)) u_pick_first (
        .mask (plan_mask),
        .idx  (first_idx),
        .any  (first_any)
    );

    assign rest_mask = q.pend & ~(NUM_HW'(1) << q.idx);

    hbs_pick #(.N(NUM_HW)) u_pick_next (
        .mask (rest_mask),
        .idx  (next_idx),
        .any  (next_any)
    );

    hbs_wdog #(.LIM_W(LIM_W)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (pb_strobe),
        .ack    (pb_ack),
        .limit  (q.lim),
        .expire (wd_expire)
    );

    assign sel_eff  = req_dw ? cfg_sel : (cfg_sel & IDX_W'(NUM_HW / 2 - 1));
    assign slot_off = q.rep ? q.roff : q.idx;

    assign pb_strobe    = (q.st == S_RUN);
    assign pb_write     = q.wr;
    assign pb_addr      = q.base + PA_W'(slot_off);
    assign pb_lane      = q.rep ? 2'b11 : q.be[2*q.idx +: 2];
    assign pb_wdata     = q.wdat[HW_BITS*q.idx +: HW_BITS];
    assign busy         = (q.st == S_RUN);
    assign cpl_done     = q.done;
    assign cpl_rdata    = q.rdat;
    assign cpl_timeout  = q.tmo;
    assign cpl_misalign = q.mis;
    assign wd_flag      = q.wflag;
    assign berr_irq     = q.wflag & cfg_irq_en;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (wd_clear) d.wflag = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.base = req_addr[ADDR_W-1:1];
                    d.roff = sel_eff;
                    d.rep  = cfg_inc_off;
                    d.wr   = req_write;
                    d.lim  = cfg_wd_limit;
                    d.wdat = req_wdata;
                    d.be   = req_be;
                    d.rdat = '0;
                    d.tmo  = 1'b0;
                    d.mis  = 1'b0;
                    d.pend = '0;
                    if (plan_mis) begin
                        d.done = 1'b1;
                        d.mis  = 1'b1;
                    end else if (!first_any) begin
                        d.done = 1'b1;
                    end else begin
                        d.st   = S_RUN;
                        d.pend = plan_mask;
                        d.idx  = first_idx;
                    end
                end
            end
            S_RUN: begin
                if (pb_ack) begin
                    if (!q.wr) d.rdat[HW_BITS*q.idx +: HW_BITS] = pb_rdata;
                    d.pend = rest_mask;
                    if (next_any) begin
                        d.idx = next_idx;
                    end else begin
                        d.st   = S_IDLE;
                        d.done = 1'b1;
                    end
                end else if (wd_expire) begin
                    d.st    = S_IDLE;
                    d.pend  = '0;
                    d.done  = 1'b1;
                    d.tmo   = 1'b1;
                    d.wflag = 1'b1;
                    d.rdat  = q.wr ? '0 : '1;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    // R6: bus cycle fields hold until acknowledged or aborted
    p_strobe_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pb_strobe && !pb_ack && !wd_expire |=> pb_strobe && $stable(pb_addr)
            && $stable(pb_lane) && $stable(pb_wdata) && $stable(pb_write));

    p_busy_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> cpl_done);

    p_mis_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_done && cpl_misalign |-> !pb_strobe && !cpl_timeout);

    p_tmo_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |=> cpl_done && cpl_timeout && !pb_strobe && wd_flag);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_flag && !wd_clear |=> wd_flag);

    p_lane_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pb_strobe && !q.rep |-> pb_lane != 2'b00);
endmodule

// File: tb/hbus_seq_test.sv
module hbus_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [7:0]  req_be = '0;
    logic        req_dw = 1'b0;
    logic        req_write = 1'b0;
    logic        cfg_inc_off = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wd_limit = '0;
    logic        cfg_irq_en = 1'b0;
    logic        wd_clear = 1'b0;
    logic        busy, cpl_done, cpl_timeout, cpl_misalign, wd_flag, berr_irq;
    logic [63:0] cpl_rdata;
    logic        pb_strobe, pb_write;
    logic [10:0] pb_addr;
    logic [1:0]  pb_lane;
    logic [15:0] pb_wdata;
    logic [15:0] pb_rdata = '0;
    logic        pb_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int nack = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    hbus_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .req_dw(req_dw), .req_write(req_write),
        .cfg_inc_off(cfg_inc_off), .cfg_sel(cfg_sel), .cfg_wd_limit(cfg_wd_limit),
        .cfg_irq_en(cfg_irq_en), .wd_clear(wd_clear), .busy(busy), .cpl_done(cpl_done),
        .cpl_rdata(cpl_rdata), .cpl_timeout(cpl_timeout), .cpl_misalign(cpl_misalign),
        .wd_flag(wd_flag), .berr_irq(berr_irq), .pb_strobe(pb_strobe), .pb_write(pb_write),
        .pb_addr(pb_addr), .pb_lane(pb_lane), .pb_wdata(pb_wdata), .pb_rdata(pb_rdata),
        .pb_ack(pb_ack)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pdat(input int a, input int n);
        return 16'((a * 16'h0123) ^ (n * 16'h1111) ^ 16'h5A00);
    endfunction

    // Reference model: builds the expected cycle list, plays the peripheral,
    // and compares every clock.
    task automatic run(input logic [11:0] a, input logic [63:0] wd, input logic [7:0] be,
                       input logic dw, input logic wr, input logic rep, input logic [1:0] sel,
                       input logic [7:0] lim, input int dly, input int hang_at,
                       input logic spam);
        int qa[$];
        int ql[$];
        int qs[$];
        int n;
        int base;
        int w;
        int cyc;
        bit mis;
        bit tmo;
        logic [63:0] exp_rd;
        string tag;
        n    = dw ? 4 : 2;
        base = int'(a[11:1]);
        mis  = dw ? (a[2:0] != 0) : (a[1:0] != 0);
        tag  = rep ? "R4" : "R2";
        if (!mis) begin
            for (int k = 0; k < n; k++) begin
                if (rep) begin
                    qa.push_back(base + int'(dw ? sel : (sel & 2'b01)));
                    ql.push_back(3);
                    qs.push_back(k);
                end else if (be[2*k +: 2] != 2'b00) begin
                    qa.push_back(base + k);
                    ql.push_back(int'(be[2*k +: 2]));
                    qs.push_back(k);
                end
            end
        end
        exp_rd = '0;
        tmo    = 0;
        w      = 0;
        cyc    = 0;
        @(negedge clk);
        req_addr = a; req_wdata = wd; req_be = be; req_dw = dw; req_write = wr;
        cfg_inc_off = rep; cfg_sel = sel; cfg_wd_limit = lim; req_valid = 1'b1;
        @(negedge clk);
        req_valid = spam;
        if (spam) begin
            req_addr = 12'h7F0; req_be = 8'hFF; req_write = ~wr; cfg_wd_limit = 8'd1;
        end
        while (qa.size() > 0) begin
            chk(busy == 1'b1, "R10", "busy during access", 64'(busy), 64'd1);
            chk(pb_strobe == 1'b1, "R6", "strobe held", 64'(pb_strobe), 64'd1);
            chk(int'(pb_addr) == qa[0], tag, "cycle address", 64'(pb_addr), 64'(qa[0]));
            chk(int'(pb_lane) == ql[0], tag, "lane selects", 64'(pb_lane), 64'(ql[0]));
            chk(pb_write == wr, tag, "direction", 64'(pb_write), 64'(wr));
            if (wr) chk(pb_wdata == wd[16*qs[0] +: 16], tag, "write data",
                        64'(pb_wdata), 64'(wd[16*qs[0] +: 16]));
            if ((hang_at < 0 || cyc < hang_at) && w == dly) begin
                pb_ack   = 1'b1;
                pb_rdata = pdat(qa[0], nack);
                if (!wr) exp_rd[16*qs[0] +: 16] = pb_rdata;
                nack++;
                void'(qa.pop_front()); void'(ql.pop_front()); void'(qs.pop_front());
                cyc++;
                w = 0;
            end else begin
                pb_ack = 1'b0;
                if (lim != 0 && w == int'(lim) - 1) begin
                    tmo = 1;
                    qa.delete(); ql.delete(); qs.delete();
                end else begin
                    w++;
                end
            end
            @(negedge clk);
            pb_ack = 1'b0;
        end
        req_valid = 1'b0;
        if (tmo && !wr) exp_rd = '1;
        chk(cpl_done == 1'b1, "R10", "done pulse", 64'(cpl_done), 64'd1);
        chk(busy == 1'b0, "R10", "busy released", 64'(busy), 64'd0);
        chk(pb_strobe == 1'b0, "R7", "no strobe at completion", 64'(pb_strobe), 64'd0);
        chk(cpl_rdata == exp_rd, "R5", "completion data", cpl_rdata, exp_rd);
        chk(cpl_timeout == tmo, "R8", "timeout flag", 64'(cpl_timeout), 64'(tmo));
        chk(cpl_misalign == mis, "R7", "misalign flag", 64'(cpl_misalign), 64'(mis));
        @(negedge clk);
        chk(cpl_done == 1'b0, "R10", "done single clock", 64'(cpl_done), 64'd0);
        chk(pb_strobe == 1'b0, "R10", "ignored request left no cycle", 64'(pb_strobe), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(busy == 0 && pb_strobe == 0 && cpl_done == 0, "R1", "reset outputs",
            {61'd0, busy, pb_strobe, cpl_done}, 64'd0);
        chk(cpl_timeout == 0 && cpl_misalign == 0 && wd_flag == 0 && berr_irq == 0, "R1",
            "reset flags", {60'd0, cpl_timeout, cpl_misalign, wd_flag, berr_irq}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && pb_strobe == 0, "R1", "idle after reset", 64'(busy), 64'd0);

        // R2/R5: full reads and writes, increment mode
        run(12'h100, 64'h0, 8'h0F, 0, 0, 0, 2'd0, 8'd0, 0, -1, 0);
        run(12'h208, 64'h1111_2222_3333_4444, 8'hFF, 1, 1, 0, 2'd0, 8'd0, 2, -1, 0);
        run(12'h040, 64'h0, 8'hFF, 1, 0, 0, 2'd0, 8'd0, 1, -1, 0);
        // R3: partial byte enables and skipped halfwords
        run(12'h300, 64'h0, 8'h03, 0, 0, 0, 2'd0, 8'd0, 0, -1, 0);
        run(12'h304, 64'hAAAA_BBBB_CCCC_DDDD, 8'hF4, 0, 1, 0, 2'd0, 8'd0, 1, -1, 0);
        run(12'h310, 64'h0, 8'hF0, 1, 0, 0, 2'd0, 8'd0, 0, -1, 0);
        run(12'h318, 64'h0, 8'h48, 1, 0, 0, 2'd0, 8'd0, 3, -1, 0);
        run(12'h320, 64'h0, 8'h00, 1, 0, 0, 2'd0, 8'd0, 0, -1, 0);
        // R4: repeat mode
        run(12'h400, 64'h0, 8'h0F, 0, 0, 1, 2'd3, 8'd0, 0, -1, 0);
        run(12'h410, 64'h0, 8'h01, 1, 0, 1, 2'd2, 8'd0, 1, -1, 0);
        run(12'h418, 64'h9999_8888_7777_6666, 8'hFF, 1, 1, 1, 2'd1, 8'd0, 0, -1, 0);
        // R7: misaligned
        run(12'h502, 64'h0, 8'h0F, 0, 0, 0, 2'd0, 8'd0, 0, -1, 0);
        run(12'h504, 64'h0, 8'hFF, 1, 1, 0, 2'd0, 8'd0, 0, -1, 0);
        // R8: boundary acknowledge in the last allowed clock, and limit 0
        run(12'h600, 64'h0, 8'h0F, 0, 0, 0, 2'd0, 8'd4, 3, -1, 0);
        run(12'h608, 64'h0, 8'hFF, 1, 0, 0, 2'd0, 8'd0, 300, -1, 0);
        chk(wd_flag == 1'b0, "R9", "no flag without timeout", 64'(wd_flag), 64'd0);
        // R8: timeout on first cycle of a read
        cfg_irq_en = 1'b1;
        run(12'h700, 64'h0, 8'hFF, 1, 0, 0, 2'd0, 8'd3, 0, 0, 0);
        chk(wd_flag == 1'b1, "R9", "sticky flag set", 64'(wd_flag), 64'd1);
        chk(berr_irq == 1'b1, "R9", "irq enabled", 64'(berr_irq), 64'd1);
        cfg_irq_en = 1'b0;
        #0.1;
        chk(berr_irq == 1'b0, "R9", "irq masked", 64'(berr_irq), 64'd0);
        repeat (5) @(negedge clk);
        chk(wd_flag == 1'b1, "R9", "flag holds", 64'(wd_flag), 64'd1);
        wd_clear = 1'b1;
        @(negedge clk);
        wd_clear = 1'b0;
        chk(wd_flag == 1'b0, "R9", "flag cleared", 64'(wd_flag), 64'd0);
        // R8: timeout on a later cycle of a write drops the rest
        run(12'h720, 64'h0123_4567_89AB_CDEF, 8'hFF, 1, 1, 0, 2'd0, 8'd5, 1, 2, 0);
        chk(wd_flag == 1'b1, "R9", "flag after write timeout", 64'(wd_flag), 64'd1);
        // R8: timeout in repeat mode read after one good cycle
        run(12'h740, 64'h0, 8'hFF, 0, 0, 1, 2'd1, 8'd2, 0, 1, 0);
        wd_clear = 1'b1;
        @(negedge clk);
        wd_clear = 1'b0;
        // R10: requests while busy are ignored
        run(12'h800, 64'h0, 8'hFF, 1, 0, 0, 2'd0, 8'd0, 2, -1, 1);
        run(12'h808, 64'h5555_6666_7777_8888, 8'h3C, 1, 1, 0, 2'd0, 8'd0, 1, -1, 1);
        chk(wd_flag == 1'b0, "R10", "ignored request changed no limit", 64'(wd_flag), 64'd0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule